// File: doc/BRIEF.md
# Serial Drive Status Requester

This block is the controller-side sequencer that asks a disk drive for its status word over a serial drive bus. A single-cycle `go` strobe accepts a control word. The block then drives the 2-bit drive select taken from that word and waits a fixed settling interval. Next it shifts a short command word out on the drive command line, timed by a free-running system clock that it generates itself. Finally it gathers a 16-bit status word that the drive sends back on its own returned status clock.

When the last status bit arrives, the word is placed in an output register and controller-ready is set. An interrupt is raised if the control word enabled one. The command can also ask the drive to clear its error state. If the drive never answers, a timeout ends the operation, flags it as incomplete and still sets controller-ready. A drive-error input is reflected continuously in the controller status word.

Top module: `drive_status_requester`

## Requirements
- R1: After reset, `drv_sel` is 0, `dr_cmd` is 0, `irq` is 0, `stat_word` is 0, and `ctl_status` reads 16'h0001 (only the ready bit, bit 0, is set).
- R2: A `go` strobe accepted while idle loads `drv_sel` from `ctl_word[9:8]`. `drv_sel` then holds that value without interruption until the next accepted `go`, so one drive is always selected.
- R3: After an accepted `go`, the first command bit does not appear on `dr_cmd` until at least SETTLE_CYC clock cycles have passed (25 cycles, 500 ns, by default).
- R4: The command word is 8 bits, sent LSB first, each bit held for one full `sys_clk` period. Bit 0 is a start marker (1), bit 1 is the get-status code (1), bit 2 is 0, bit 3 copies `ctl_word[3]` (clear drive error), and bits 7:4 are 0. `dr_cmd` changes only in a cycle where `sys_clk` falls.
- R5: `dr_cmd` is 0 whenever no command word is being shifted.
- R6: The status word is 16 bits, LSB first, each bit sampled at a rising edge of `stat_clk` after synchronisation to `clk`. When the 16th bit arrives the word is loaded into `stat_word`, and further `stat_clk` edges are ignored.
- R7: `ctl_status[0]` (ready) is 0 from an accepted `go` until the operation ends, then returns to 1. `ctl_status[6]` echoes the latched interrupt enable (`ctl_word[6]`).
- R8: `irq` is 1 after an operation ends only if `ctl_word[6]` was 1 at its `go`; it stays 0 otherwise, and is cleared by the next accepted `go`.
- R9: While `drv_err` is 1, `ctl_status[14]` and `ctl_status[15]` read 1 one cycle later; when it returns to 0 and no operation-incomplete flag is set, both read 0.
- R10: If no rising edge of `stat_clk` is seen within TIMEOUT_CYC cycles once the command word has been sent, the operation ends with `ctl_status[10]` and `ctl_status[15]` set, ready set, and `stat_word` unchanged. The next accepted `go` clears bit 10.
- R11: A `go` strobe while an operation is in progress has no effect: `drv_sel` and the command word sent are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Single-cycle request to read drive status |
| ctl_word | input | 16 | Control word: [9:8] drive, [6] interrupt enable, [3] clear drive error |
| drv_err | input | 1 | Drive error line from the selected drive |
| stat_clk | input | 1 | Status clock returned by the drive (asynchronous) |
| stat_dat | input | 1 | Serial status data from the drive |
| drv_sel | output | 2 | Drive select |
| sys_clk | output | 1 | Free-running system clock to the drive bus |
| dr_cmd | output | 1 | Serial drive command line |
| stat_word | output | 16 | Last status word received |
| ctl_status | output | 16 | Controller status: [0] ready, [6] ie, [9:8] drive, [10] incomplete, [14] drive error, [15] composite error |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check these properties: the command line moves only on a falling system-clock edge and stays low while idle; the select lines hold steady during an operation; the first marker bit never comes before the settling interval; a status word completes only on a synchronised status-clock edge; and the interrupt rises only when a transfer finishes. The exact bit pattern of the command word, the LSB-first assembly of the returned status and the rejection of surplus status clocks need the bench's drive model. The same holds for the timeout path and its clearing by the next request, and for the refusal of a `go` that arrives mid-operation.

// File: rtl/drive_status_pkg.sv
package drive_status_pkg;

    localparam int CMD_W  = 8;
    localparam int STAT_W = 16;

    // control word field positions
    localparam int CW_SEL_LO = 8;
    localparam int CW_IE     = 6;
    localparam int CW_CLR    = 3;

    // controller status bit positions
    localparam int CS_READY  = 0;
    localparam int CS_IE     = 6;
    localparam int CS_SEL_LO = 8;
    localparam int CS_INCOMP = 10;
    localparam int CS_DERR   = 14;
    localparam int CS_COMP   = 15;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SEND,
        ST_RECV
    } seq_state_t;

    typedef struct packed {
        logic [1:0] sel;
        logic       ie;
        logic       clr;
    } req_t;

    // marker in bit 0, get-status code in bit 1, error clear in bit 3
    function automatic logic [CMD_W-1:0] build_cmd(input logic clr);
        logic [CMD_W-1:0] w;
        w        = '0;
        w[0]     = 1'b1;
        w[1]     = 1'b1;
        w[CW_CLR] = clr;
        return w;
    endfunction

endpackage

// File: rtl/sysclk_gen.sv
module sysclk_gen #(
    parameter int HALF_DIV = 6
) (
    input  logic clk,
    input  logic rst,
    output logic sclk,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == CW'(HALF_DIV - 1));
    assign fall_tick = wrap && sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cmd_serializer.sv
module cmd_serializer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         tick,
    output logic         line,
    output logic         done
);
    localparam int NW = $clog2(W + 1);

    logic [W-1:0]  sh;
    logic [NW-1:0] n;
    logic          act;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            n    <= '0;
            act  <= 1'b0;
            line <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                sh  <= word;
                n   <= '0;
                act <= 1'b1;
            end else if (act && tick) begin
                if (n == NW'(W)) begin
                    line <= 1'b0;
                    act  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    line <= sh[0];
                    sh   <= sh >> 1;
                    n    <= n + 1'b1;
                end
            end
        end
    end

    // R5: line can only be high while a word is in flight
    p_quiet_when_inactive_r5: assert property (@(posedge clk) disable iff (rst)
        !act |=> !line);

endmodule

// File: rtl/status_deserializer.sv
module status_deserializer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic         sclk_in,
    input  logic         sdat_in,
    output logic         edge_seen,
    output logic         done,
    output logic [W-1:0] word
);
    localparam int NW = $clog2(W + 1);

    logic          c1, c2, c3, d1, d2;
    logic [W-1:0]  sh;
    logic [NW-1:0] cnt;

    assign edge_seen = c2 && !c3;

    always_ff @(posedge clk) begin
        if (rst) begin
            {c1, c2, c3} <= '0;
            {d1, d2}     <= '0;
        end else begin
            c1 <= sclk_in;
            c2 <= c1;
            c3 <= c2;
            d1 <= sdat_in;
            d2 <= d1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            cnt  <= '0;
            done <= 1'b0;
            word <= '0;
        end else begin
            done <= 1'b0;
            if (!arm) begin
                cnt <= '0;
            end else if (edge_seen) begin
                sh <= {d2, sh[W-1:1]};
                if (cnt == NW'(W - 1)) begin
                    word <= {d2, sh[W-1:1]};
                    done <= 1'b1;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R6: a word completes only on a synchronised status clock edge
    p_done_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(edge_seen && arm));

endmodule

// File: rtl/drive_status_requester.sv
module drive_status_requester
    import drive_status_pkg::*;
#(
    parameter int HALF_DIV    = 6,
    parameter int SETTLE_CYC  = 25,
    parameter int TIMEOUT_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [15:0]       ctl_word,
    input  logic              drv_err,
    input  logic              stat_clk,
    input  logic              stat_dat,
    output logic [1:0]        drv_sel,
    output logic              sys_clk,
    output logic              dr_cmd,
    output logic [STAT_W-1:0] stat_word,
    output logic [15:0]       ctl_status,
    output logic              irq
);
    localparam int LIM = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
    localparam int TW  = $clog2(LIM + 1);

    seq_state_t        state;
    req_t              req;
    logic [TW-1:0]     timer;
    logic              ready_q, incomp_q, derr_q;
    logic              fall_tick, tx_load, tx_done;
    logic              rx_edge, rx_done;
    logic [STAT_W-1:0] rx_word;

    sysclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst(rst), .sclk(sys_clk), .fall_tick(fall_tick)
    );

    assign tx_load = (state == ST_SETTLE) && (timer == TW'(SETTLE_CYC - 1));

    cmd_serializer #(.W(CMD_W)) u_tx (
        .clk(clk), .rst(rst), .load(tx_load), .word(build_cmd(req.clr)),
        .tick(fall_tick), .line(dr_cmd), .done(tx_done)
    );

    status_deserializer #(.W(STAT_W)) u_rx (
        .clk(clk), .rst(rst), .arm(state == ST_RECV),
        .sclk_in(stat_clk), .sdat_in(stat_dat),
        .edge_seen(rx_edge), .done(rx_done), .word(rx_word)
    );

    always_ff @(posedge clk) begin
        derr_q <= drv_err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            req       <= '0;
            timer     <= '0;
            ready_q   <= 1'b1;
            incomp_q  <= 1'b0;
            stat_word <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (go) begin
                    req.sel  <= ctl_word[CW_SEL_LO +: 2];
                    req.ie   <= ctl_word[CW_IE];
                    req.clr  <= ctl_word[CW_CLR];
                    ready_q  <= 1'b0;
                    incomp_q <= 1'b0;
                    timer    <= '0;
                    state    <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (tx_load) begin
                        timer <= '0;
                        state <= ST_SEND;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                ST_SEND: if (tx_done) begin
                    timer <= '0;
                    state <= ST_RECV;
                end
                ST_RECV: begin
                    if (rx_done) begin
                        stat_word <= rx_word;
                        ready_q   <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (rx_edge) begin
                        timer <= '0;
                    end else if (timer == TW'(TIMEOUT_CYC - 1)) begin
                        incomp_q <= 1'b1;
                        ready_q  <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign drv_sel = req.sel;
    assign irq     = ready_q && req.ie;

    always_comb begin
        ctl_status                    = '0;
        ctl_status[CS_READY]          = ready_q;
        ctl_status[CS_IE]             = req.ie;
        ctl_status[CS_SEL_LO +: 2]    = req.sel;
        ctl_status[CS_INCOMP]         = incomp_q;
        ctl_status[CS_DERR]           = derr_q;
        ctl_status[CS_COMP]           = derr_q || incomp_q;
    end

    // checker-only count of cycles since the last accepted request
    logic [TW-1:0] since_go;
    always_ff @(posedge clk) begin
        if (rst) since_go <= '0;
        else if (state == ST_IDLE && go) since_go <= '0;
        else if (since_go != TW'(LIM)) since_go <= since_go + 1'b1;
    end

    // R2: the selected drive does not move during an operation
    p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(drv_sel));

    // R3: the marker never leaves before the settling interval
    p_settle_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(dr_cmd) |-> (since_go >= TW'(SETTLE_CYC)));

    // R4: command bits change only on a falling system clock
    p_fall_edge_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(dr_cmd) |-> $fell(sys_clk));

    // R5: command line quiet while idle
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !dr_cmd);

    // R8: interrupt rises only when a transfer finishes
    p_irq_on_finish_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(state) == ST_RECV));

endmodule

// File: tb/drive_status_requester_test.sv
`timescale 1ns/1ps
module drive_status_requester_test;

    localparam int HALF   = 6;
    localparam int SETTLE = 25;
    localparam int TMO    = 2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [15:0] ctl_word = '0;
    logic        drv_err = 1'b0;
    logic        stat_clk = 1'b0;
    logic        stat_dat = 1'b0;
    logic [1:0]  drv_sel;
    logic        sys_clk;
    logic        dr_cmd;
    logic [15:0] stat_word;
    logic [15:0] ctl_status;
    logic        irq;

    drive_status_requester #(.HALF_DIV(HALF), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst(rst), .go(go), .ctl_word(ctl_word), .drv_err(drv_err),
        .stat_clk(stat_clk), .stat_dat(stat_dat), .drv_sel(drv_sel),
        .sys_clk(sys_clk), .dr_cmd(dr_cmd), .stat_word(stat_word),
        .ctl_status(ctl_status), .irq(irq)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // drive-side model: capture command bits at rising system clock
    bit         cap_armed = 0;
    bit         cap_done  = 0;
    int         cap_n     = 0;
    int         first_cyc = 0;
    logic [7:0] cap_w     = '0;

    always @(posedge sys_clk) begin
        if (cap_armed && !cap_done) begin
            if (cap_n == 0) begin
                if (dr_cmd) begin
                    cap_w[0]  = 1'b1;
                    cap_n     = 1;
                    first_cyc = cyc;
                end
            end else begin
                cap_w[cap_n] = dr_cmd;
                cap_n        = cap_n + 1;
                if (cap_n == 8) cap_done = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #5_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    int go_cyc = 0;

    task automatic pulse_go(input logic [1:0] drv, input bit ie, input bit clr);
        @(negedge clk);
        ctl_word = '0;
        ctl_word[9:8] = drv;
        ctl_word[6]   = ie;
        ctl_word[3]   = clr;
        go = 1'b1;
        go_cyc = cyc;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic arm_capture();
        cap_done  = 0;
        cap_n     = 0;
        cap_w     = '0;
        cap_armed = 1;
    endtask

    // status bits change while stat_clk is low, then 3 surplus clocks
    task automatic respond(input logic [15:0] w);
        #200;
        for (int i = 0; i < 19; i++) begin
            stat_dat = (i < 16) ? w[i] : ~w[i - 16];
            #60 stat_clk = 1'b1;
            #60 stat_clk = 1'b0;
        end
        stat_dat = 1'b0;
    endtask

    task automatic t_reset();
        chk(drv_sel == 2'd0, "R1 drv_sel", drv_sel, 0);
        chk(dr_cmd == 1'b0, "R1 dr_cmd", dr_cmd, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(stat_word == 16'h0, "R1 stat_word", stat_word, 0);
        chk(ctl_status == 16'h0001, "R1 ctl_status", ctl_status, 16'h0001);
    endtask

    task automatic t_status(input logic [1:0] drv, input bit ie, input bit clr, input logic [15:0] w);
        logic [7:0] exp_cmd;
        exp_cmd = {4'b0, clr, 1'b0, 1'b1, 1'b1};
        arm_capture();
        pulse_go(drv, ie, clr);
        chk(ctl_status[0] == 1'b0, "R7 busy ready", ctl_status[0], 0);
        chk(irq == 1'b0, "R8 irq cleared", irq, 0);
        chk(drv_sel == drv, "R2 drv_sel", drv_sel, drv);
        wait (cap_done);
        cap_armed = 0;
        chk(cap_w == exp_cmd, "R4 command word", cap_w, exp_cmd);
        chk(first_cyc - go_cyc >= SETTLE + HALF, "R3 settle", first_cyc - go_cyc, SETTLE + HALF);
        chk(first_cyc - go_cyc <= SETTLE + 3 * HALF + 4, "R3 settle bound", first_cyc - go_cyc, SETTLE + 3 * HALF + 4);
        respond(w);
        wait (ctl_status[0]);
        repeat (10) @(negedge clk);
        chk(stat_word == w, "R6 stat_word", stat_word, w);
        chk(ctl_status[0] == 1'b1, "R7 ready", ctl_status[0], 1);
        chk(ctl_status[6] == ie, "R7 ie echo", ctl_status[6], ie);
        chk(irq == ie, "R8 irq", irq, ie);
        chk(dr_cmd == 1'b0, "R5 dr_cmd idle", dr_cmd, 0);
        chk(ctl_status[10] == 1'b0, "R10 incomplete clear", ctl_status[10], 0);
        chk(drv_sel == drv, "R2 drv_sel held", drv_sel, drv);
    endtask

    task automatic t_busy_ignore(input logic [15:0] w);
        arm_capture();
        pulse_go(2'd3, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        pulse_go(2'd0, 1'b1, 1'b1);
        chk(drv_sel == 2'd3, "R11 drv_sel after busy go", drv_sel, 3);
        wait (cap_done);
        cap_armed = 0;
        chk(cap_w == 8'h03, "R11 command unchanged", cap_w, 8'h03);
        respond(w);
        wait (ctl_status[0]);
        @(negedge clk);
        chk(drv_sel == 2'd3, "R11 drv_sel at end", drv_sel, 3);
        chk(irq == 1'b0, "R11 irq from first go", irq, 0);
    endtask

    task automatic t_timeout(input logic [15:0] prev);
        pulse_go(2'd1, 1'b1, 1'b0);
        wait (ctl_status[0]);
        @(negedge clk);
        chk(ctl_status[10] == 1'b1, "R10 incomplete", ctl_status[10], 1);
        chk(ctl_status[15] == 1'b1, "R10 composite", ctl_status[15], 1);
        chk(stat_word == prev, "R10 stat_word kept", stat_word, prev);
        chk(irq == 1'b1, "R10 irq", irq, 1);
    endtask

    task automatic t_drive_error();
        @(negedge clk);
        drv_err = 1'b1;
        repeat (2) @(negedge clk);
        chk(ctl_status[14] == 1'b1, "R9 drive error", ctl_status[14], 1);
        chk(ctl_status[15] == 1'b1, "R9 composite", ctl_status[15], 1);
        drv_err = 1'b0;
        repeat (2) @(negedge clk);
        chk(ctl_status[14] == 1'b0, "R9 drive error clear", ctl_status[14], 0);
        chk(ctl_status[15] == 1'b0, "R9 composite clear", ctl_status[15], 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_status(2'd2, 1'b1, 1'b0, 16'hA5C3);
        t_status(2'd1, 1'b0, 1'b1, 16'h8001);
        t_busy_ignore(16'h3C5A);
        t_timeout(16'h3C5A);
        t_status(2'd0, 1'b0, 1'b0, 16'h7FFE);
        t_drive_error();
        finish_run();
    end

endmodule